// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block brings a dynamic RAM from power-up to a usable state and then keeps its contents alive. After reset it holds the row strobe inactive for a programmable pause. It then runs a fixed number of dummy row-strobe cycles to wake the array's dynamic nodes, and only after that raises `ready`. From then on an interval timer schedules RAS-only refresh cycles. The row for each cycle comes from an internal row counter that steps after every completed refresh and wraps at the top, so every row is visited once per retention period.

The block shares the memory pins with an access controller through a request/grant handshake. Each row-strobe cycle is first requested and is started only once a grant arrives. Refreshes that cannot be granted at once are counted as pending, up to a limit. When the limit is reached, an urgent flag asks the controller to give refresh priority. If the controller grants while it still holds column strobe low after a read, the cycle is flagged as a hidden refresh, so the controller keeps the read data on the output. An idle timer watches all row-strobe activity, from the sequencer and from the controller. If no activity is seen for the retention period, `ready` is dropped and the warm-up runs again.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, `ras_n` is 1, `ready` is 0 and `ref_req` is 0, and `ras_n` stays 1 for at least `PAUSE_CYC` clock cycles after reset is released.
- R2: After the pause, exactly `WARMUP_CNT` row-strobe cycles are run with `ready` at 0. `ready` rises after the last of them completes. Warm-up cycles drive the current row counter value and do not advance it.
- R3: While `ready` is 1, one refresh falls due every `INTERVAL_CYC` cycles. When the bus is granted without delay, successive refresh strobes are exactly `INTERVAL_CYC` cycles apart.
- R4: Refreshes that fall due while not granted are held as pending, up to `MAX_PEND`. Further due refreshes are dropped. `ref_urgent` is 1 while the pending count equals `MAX_PEND`. Once grants resume, exactly the held refreshes run back to back.
- R5: `ref_req` stays 1 until `ref_grant` is seen. `ras_n` falls only in the cycle after `ref_req` and `ref_grant` are both 1.
- R6: `ras_n` stays 0 for exactly `RAS_LOW_CYC` cycles per cycle. After it rises it stays 1 for at least `PRE_CYC` cycles.
- R7: A refresh drives the row counter on the low `ROW_W` bits of `ref_addr`; the upper bits are 0. The counter steps by one after each completed refresh and wraps from 255 to 0.
- R8: If `cas_hold` is 1 in the cycle the grant is taken, `hidden_cyc` is 1 while that cycle's strobe is active. Otherwise `hidden_cyc` is 0.
- R9: If `ready` is 1 and no row-strobe activity is seen for `IDLE_CYC` cycles, `ready` drops to 0, pending refreshes are cleared and the warm-up of R2 runs again.
- R10: A pulse on `ctl_ras_act` (the controller's own row strobe) restarts the idle timer, so `ready` stays 1 while such pulses keep coming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_req | output | 1 | Request for the memory bus for one row-strobe cycle |
| ref_grant | input | 1 | Bus granted by the access controller |
| ref_urgent | output | 1 | Pending refresh count at its limit |
| cas_hold | input | 1 | Controller still holds column strobe low after a read |
| ctl_ras_act | input | 1 | Controller is driving the row strobe this cycle |
| ras_n | output | 1 | Row strobe for warm-up and refresh cycles, active low |
| ref_addr | output | ADDR_W | Row address for the current cycle |
| hidden_cyc | output | 1 | Current refresh is a hidden refresh |
| ready | output | 1 | Memory initialised and ready for access |

## Verification
The checker watches on every cycle the local timing rules. These are the grant-before-strobe ordering, a held request, the exact strobe width and minimum precharge, and the minimum pause after reset. It also checks the warm-up count before `ready`, the unit step of the row address, the hidden flag against `cas_hold`, and that urgency only appears in the ready state. The bench scenarios are what show the long-range behaviour. They show the refresh spacing and the pending limit under a denied grant, the dropped surplus ticks, the idle timeout with and without controller activity, the repeated warm-up, and the wrap of the row counter after 256 refreshes.

// File: rtl/dram_rf_pkg.sv
package dram_rf_pkg;

   typedef enum logic [1:0] {
      PH_PAUSE = 2'd0,
      PH_WARM  = 2'd1,
      PH_RUN   = 2'd2
   } phase_t;

   typedef enum logic [1:0] {
      CY_IDLE = 2'd0,
      CY_REQ  = 2'd1,
      CY_LOW  = 2'd2,
      CY_PRE  = 2'd3
   } cyc_t;

endpackage

// File: rtl/dram_rf_ticker.sv
module dram_rf_ticker #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   initial begin
      if (LIMIT < 1) $error("dram_rf_ticker: LIMIT must be at least 1");
   end

   generate
      if (LIMIT <= 1) begin : g_every
         assign tick = !clr;
      end else begin : g_count
         localparam int unsigned CW = $clog2(LIMIT);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clr || cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end

         assign tick = !clr && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/dram_rf_pending.sv
module dram_rf_pending #(
   parameter int unsigned MAX_PEND = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   input  logic dec,
   output logic nonzero,
   output logic full
);

   localparam int unsigned PW = $clog2(MAX_PEND + 1);
   localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

   logic [PW-1:0] cnt;
   logic          can_inc;
   logic          can_dec;

   initial begin
      if (MAX_PEND < 1) $error("dram_rf_pending: MAX_PEND must be at least 1");
   end

   assign can_inc = inc && (cnt != TOP);
   assign can_dec = dec && (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (can_inc && !can_dec) begin
         cnt <= cnt + 1'b1;
      end else if (can_dec && !can_inc) begin
         cnt <= cnt - 1'b1;
      end else if (can_dec && inc) begin
         cnt <= cnt;
      end
   end

   assign nonzero = (cnt != '0);
   assign full    = (cnt == TOP);

endmodule

// File: rtl/dram_rf_ras_cycle.sv
module dram_rf_ras_cycle
   import dram_rf_pkg::*;
#(
   parameter int unsigned RAS_LOW_CYC = 8,
   parameter int unsigned PRE_CYC     = 6,
   parameter bit          HIDDEN_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic grant,
   input  logic cas_hold,
   output logic req,
   output logic ras_n,
   output logic done,
   output logic hidden_cyc
);

   localparam int unsigned MAXC = (RAS_LOW_CYC > PRE_CYC) ? RAS_LOW_CYC : PRE_CYC;
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] LOW_LAST = CW'(RAS_LOW_CYC - 1);
   localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYC - 1);

   cyc_t          state;
   logic [CW-1:0] cnt;
   logic          active;

   initial begin
      if (RAS_LOW_CYC < 1) $error("dram_rf_ras_cycle: RAS_LOW_CYC must be at least 1");
      if (PRE_CYC < 1)     $error("dram_rf_ras_cycle: PRE_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CY_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            CY_IDLE: begin
               if (want) state <= CY_REQ;
            end
            CY_REQ: begin
               if (grant) begin
                  state <= CY_LOW;
                  cnt   <= LOW_LAST;
               end
            end
            CY_LOW: begin
               if (cnt == '0) begin
                  state <= CY_PRE;
                  cnt   <= PRE_LAST;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            CY_PRE: begin
               if (cnt == '0) begin
                  state <= CY_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= CY_IDLE;
         endcase
      end
   end

   assign req    = (state == CY_REQ);
   assign ras_n  = (state != CY_LOW);
   assign done   = (state == CY_PRE) && (cnt == '0);
   assign active = (state == CY_LOW) || (state == CY_PRE);

   generate
      if (HIDDEN_EN) begin : g_hidden
         logic hid_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hid_q <= 1'b0;
            end else if (state == CY_REQ && grant) begin
               hid_q <= cas_hold;
            end
         end
         assign hidden_cyc = hid_q && active;
      end else begin : g_no_hidden
         logic unused_hold;
         assign unused_hold = cas_hold & active;
         assign hidden_cyc  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import dram_rf_pkg::*;
#(
   parameter int unsigned PAUSE_CYC    = 20000,
   parameter int unsigned WARMUP_CNT   = 8,
   parameter int unsigned INTERVAL_CYC = 1560,
   parameter int unsigned IDLE_CYC     = 400000,
   parameter int unsigned RAS_LOW_CYC  = 8,
   parameter int unsigned PRE_CYC      = 6,
   parameter int unsigned MAX_PEND     = 8,
   parameter int unsigned ROW_W        = 8,
   parameter int unsigned ADDR_W       = 9,
   parameter bit          HIDDEN_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ref_req,
   input  logic              ref_grant,
   output logic              ref_urgent,
   input  logic              cas_hold,
   input  logic              ctl_ras_act,
   output logic              ras_n,
   output logic [ADDR_W-1:0] ref_addr,
   output logic              hidden_cyc,
   output logic              ready
);

   localparam int unsigned WARM_W = $clog2(WARMUP_CNT + 1);
   localparam logic [WARM_W-1:0] WARM_INIT = WARM_W'(WARMUP_CNT);

   initial begin
      if (WARMUP_CNT < 1)   $error("dram_refresh_seq: WARMUP_CNT must be at least 1");
      if (ADDR_W < ROW_W)   $error("dram_refresh_seq: ADDR_W must cover ROW_W");
      if (IDLE_CYC <= INTERVAL_CYC + RAS_LOW_CYC + PRE_CYC)
         $error("dram_refresh_seq: IDLE_CYC must exceed one refresh interval");
   end

   phase_t            phase;
   logic [WARM_W-1:0] warm_left;
   logic [ROW_W-1:0]  row;

   logic pause_tick, interval_tick, idle_tick;
   logic pend_nz, pend_full;
   logic want, cyc_done, cyc_ras_n;
   logic in_run;

   assign in_run = (phase == PH_RUN);

   dram_rf_ticker #(.LIMIT(PAUSE_CYC)) u_pause (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase != PH_PAUSE),
      .tick  (pause_tick)
   );

   dram_rf_ticker #(.LIMIT(INTERVAL_CYC)) u_interval (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_run),
      .tick  (interval_tick)
   );

   dram_rf_ticker #(.LIMIT(IDLE_CYC)) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_run || !cyc_ras_n || ctl_ras_act),
      .tick  (idle_tick)
   );

   dram_rf_pending #(.MAX_PEND(MAX_PEND)) u_pending (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!in_run),
      .inc     (interval_tick),
      .dec     (cyc_done && in_run),
      .nonzero (pend_nz),
      .full    (pend_full)
   );

   assign want = (phase == PH_WARM) || (in_run && pend_nz);

   dram_rf_ras_cycle #(
      .RAS_LOW_CYC (RAS_LOW_CYC),
      .PRE_CYC     (PRE_CYC),
      .HIDDEN_EN   (HIDDEN_EN)
   ) u_cycle (
      .clk        (clk),
      .rst_n      (rst_n),
      .want       (want),
      .grant      (ref_grant),
      .cas_hold   (cas_hold),
      .req        (ref_req),
      .ras_n      (cyc_ras_n),
      .done       (cyc_done),
      .hidden_cyc (hidden_cyc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_PAUSE;
         warm_left <= WARM_INIT;
      end else begin
         unique case (phase)
            PH_PAUSE: begin
               if (pause_tick) begin
                  phase     <= PH_WARM;
                  warm_left <= WARM_INIT;
               end
            end
            PH_WARM: begin
               if (cyc_done) begin
                  if (warm_left == WARM_W'(1)) phase <= PH_RUN;
                  warm_left <= warm_left - 1'b1;
               end
            end
            PH_RUN: begin
               if (idle_tick) begin
                  phase     <= PH_WARM;
                  warm_left <= WARM_INIT;
               end
            end
            default: phase <= PH_PAUSE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (cyc_done && in_run) begin
         row <= row + 1'b1;
      end
   end

   generate
      if (ADDR_W > ROW_W) begin : g_addr_pad
         assign ref_addr = {{(ADDR_W - ROW_W){1'b0}}, row};
      end else begin : g_addr_exact
         assign ref_addr = row;
      end
   endgenerate

   assign ras_n      = cyc_ras_n;
   assign ready      = in_run;
   assign ref_urgent = in_run && pend_full;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
   parameter int unsigned PAUSE_CYC   = 20000,
   parameter int unsigned WARMUP_CNT  = 8,
   parameter int unsigned RAS_LOW_CYC = 8,
   parameter int unsigned PRE_CYC     = 6,
   parameter int unsigned ROW_W       = 8,
   parameter int unsigned ADDR_W      = 9,
   parameter bit          HIDDEN_EN   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              ref_req,
   input logic              ref_grant,
   input logic [ADDR_W-1:0] ref_addr,
   input logic              ready,
   input logic              ref_urgent,
   input logic              hidden_cyc,
   input logic              cas_hold
);

   localparam logic [ADDR_W-1:0] ROW_MASK = ADDR_W'((64'd1 << ROW_W) - 64'd1);

   int unsigned since_rst;
   int unsigned lo_cnt;
   int unsigned hi_cnt;
   int unsigned warm_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= 0;
         lo_cnt    <= 0;
         hi_cnt    <= PRE_CYC;
         warm_seen <= 0;
      end else begin
         if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
         lo_cnt <= ras_n ? 0 : lo_cnt + 1;
         if (!ras_n)               hi_cnt <= 0;
         else if (hi_cnt < PRE_CYC) hi_cnt <= hi_cnt + 1;
         if (ready)                     warm_seen <= 0;
         else if (ras_n && lo_cnt == 0) warm_seen <= warm_seen;
         else if (!ras_n && lo_cnt == 0) warm_seen <= warm_seen + 1;
      end
   end

   assert_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> since_rst >= PAUSE_CYC);

   assert_warmup_before_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> warm_seen >= WARMUP_CNT);

   assert_urgent_only_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_urgent |-> ready);

   assert_grant_before_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> $past(ref_req && ref_grant));

   assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_grant) |=> ref_req);

   assert_ras_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> lo_cnt == RAS_LOW_CYC);

   assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> hi_cnt >= PRE_CYC);

   assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && $past(!ras_n)) |-> $stable(ref_addr));

   assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready) && ref_addr != $past(ref_addr))
         |-> ref_addr == (($past(ref_addr) + 1'b1) & ROW_MASK));

   assert_hidden_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> hidden_cyc == (HIDDEN_EN && $past(cas_hold)));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
   .PAUSE_CYC   (PAUSE_CYC),
   .WARMUP_CNT  (WARMUP_CNT),
   .RAS_LOW_CYC (RAS_LOW_CYC),
   .PRE_CYC     (PRE_CYC),
   .ROW_W       (ROW_W),
   .ADDR_W      (ADDR_W),
   .HIDDEN_EN   (HIDDEN_EN)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ras_n      (ras_n),
   .ref_req    (ref_req),
   .ref_grant  (ref_grant),
   .ref_addr   (ref_addr),
   .ready      (ready),
   .ref_urgent (ref_urgent),
   .hidden_cyc (hidden_cyc),
   .cas_hold   (cas_hold)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int PAUSE      = 20;
   localparam int WARM       = 8;
   localparam int INTERVAL   = 40;
   localparam int IDLE       = 300;
   localparam int RLOW       = 3;
   localparam int PRE        = 2;
   localparam int MAXP       = 3;
   localparam int AW         = 9;
   localparam int WD_CYCLES  = 100000;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic          rdy;
      logic          hid;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_grant = 1'b0;
   logic          cas_hold = 1'b0;
   logic          ctl_ras_act = 1'b0;
   logic          ref_req, ref_urgent, ras_n, hidden_cyc, ready;
   logic [AW-1:0] ref_addr;

   int n_checks = 0;
   int n_fail   = 0;

   exp_t q[$];
   int   model_warm = WARM;
   int   model_row  = 0;
   bit   grant_en   = 1'b1;

   int  cyc = 0;
   int  fall_cnt = 0;
   int  warm_falls = 0;
   int  first_fall = -1;
   int  last_fall = 0;
   int  last_addr = -1;
   int  hid_seen = 0;
   int  low_len = 0;
   bit  prev_ras = 1'b1;
   bit  per_chk = 1'b0;
   bit  saw_wrap = 1'b0;
   bit  wd_hit = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_refresh_seq #(
      .PAUSE_CYC    (PAUSE),
      .WARMUP_CNT   (WARM),
      .INTERVAL_CYC (INTERVAL),
      .IDLE_CYC     (IDLE),
      .RAS_LOW_CYC  (RLOW),
      .PRE_CYC      (PRE),
      .MAX_PEND     (MAXP),
      .ROW_W        (8),
      .ADDR_W       (AW),
      .HIDDEN_EN    (1'b1)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_req     (ref_req),
      .ref_grant   (ref_grant),
      .ref_urgent  (ref_urgent),
      .cas_hold    (cas_hold),
      .ctl_ras_act (ctl_ras_act),
      .ras_n       (ras_n),
      .ref_addr    (ref_addr),
      .hidden_cyc  (hidden_cyc),
      .ready       (ready)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
      end
   endtask

   always @(posedge clk) if (rst_n) cyc++;

   // Driver side of the scoreboard: each grant pushes the expected strobe.
   always @(negedge clk) begin
      if (rst_n && grant_en && ref_req) begin
         ref_grant = 1'b1;
         q.push_back(exp_t'{addr: AW'(model_row), rdy: (model_warm == 0), hid: cas_hold});
         if (model_warm > 0) model_warm--;
         else model_row = (model_row + 1) % 256;
      end else begin
         ref_grant = 1'b0;
      end
   end

   // Monitor side: pops and compares at every falling row strobe.
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_ras && !ras_n) begin
            exp_t e;
            fall_cnt++;
            if (first_fall < 0) first_fall = cyc;
            if (!ready) warm_falls++;
            if (hidden_cyc) hid_seen++;
            if (q.size() == 0) begin
               check(1'b0, "R5 strobe without a grant", 1, 0);
            end else begin
               e = q.pop_front();
               check(ref_addr == e.addr, "R7 row address", int'(ref_addr), int'(e.addr));
               check(ready == e.rdy, "R2 ready during strobe", int'(ready), int'(e.rdy));
               check(hidden_cyc == e.hid, "R8 hidden flag", int'(hidden_cyc), int'(e.hid));
            end
            if (ready) begin
               if (last_addr == 255 && ref_addr == 0) saw_wrap = 1'b1;
               last_addr = int'(ref_addr);
               if (per_chk && last_fall > 0)
                  check(cyc - last_fall == INTERVAL, "R3 refresh spacing", cyc - last_fall, INTERVAL);
               last_fall = cyc;
            end
         end
         if (!prev_ras && ras_n) begin
            check(low_len == RLOW, "R6 strobe low width", low_len, RLOW);
            low_len = 0;
         end
         if (!ras_n) low_len++;
         prev_ras = ras_n;
      end
   end

   task automatic wait_falls(input int n);
      int target;
      target = fall_cnt + n;
      wait (fall_cnt >= target);
   endtask

   task automatic run_test();
      int n0;
      repeat (3) @(negedge clk);
      check(ras_n == 1'b1, "R1 reset ras_n", int'(ras_n), 1);
      check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
      check(ref_req == 1'b0, "R1 reset request", int'(ref_req), 0);
      rst_n = 1'b1;

      repeat (PAUSE - 2) @(negedge clk);
      check(ras_n == 1'b1 && ref_req == 1'b0, "R1 quiet during pause", int'(ref_req), 0);

      wait (ready);
      check(warm_falls == WARM, "R2 warm-up strobe count", warm_falls, WARM);
      check(first_fall >= PAUSE, "R1 first strobe after pause", first_fall, PAUSE);

      // R3: steady refresh spacing
      per_chk = 1'b1;
      wait_falls(5);

      // R8: hidden refresh while column strobe is held
      cas_hold = 1'b1;
      wait_falls(3);
      cas_hold = 1'b0;
      per_chk = 1'b0;
      check(hid_seen == 3, "R8 hidden refresh count", hid_seen, 3);

      // R4 / R5: grants withheld, refreshes deferred
      grant_en = 1'b0;
      n0 = fall_cnt;
      repeat (4 * INTERVAL) @(negedge clk);
      check(fall_cnt == n0, "R5 no strobe without grant", fall_cnt - n0, 0);
      check(ref_req == 1'b1, "R5 request held", int'(ref_req), 1);
      check(ref_urgent == 1'b1, "R4 urgent at pending limit", int'(ref_urgent), 1);
      @(posedge clk);
      grant_en = 1'b1;
      n0 = fall_cnt;
      repeat (30) @(negedge clk);
      check(fall_cnt - n0 == MAXP, "R4 burst equals pending limit", fall_cnt - n0, MAXP);
      check(ref_urgent == 1'b0, "R4 urgent cleared", int'(ref_urgent), 0);

      // R10: controller activity keeps the memory alive
      wait_falls(1);
      grant_en = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (50) @(negedge clk);
         ctl_ras_act = 1'b1;
         @(negedge clk);
         ctl_ras_act = 1'b0;
      end
      check(ready == 1'b1, "R10 ready kept by controller activity", int'(ready), 1);

      // R9: no activity for the idle limit
      repeat (IDLE + 20) @(negedge clk);
      check(ready == 1'b0, "R9 ready dropped after idle", int'(ready), 0);
      check(ref_urgent == 1'b0, "R9 pending cleared", int'(ref_urgent), 0);
      warm_falls = 0;
      @(posedge clk);
      model_warm = WARM;
      grant_en = 1'b1;
      wait (ready);
      check(warm_falls == WARM, "R9 warm-up rerun count", warm_falls, WARM);

      // R7: run long enough for the row counter to wrap
      repeat (262 * INTERVAL) @(negedge clk);
      check(saw_wrap, "R7 row wrap 255 to 0", int'(saw_wrap), 1);
      check(ref_addr[AW-1:8] == '0, "R7 upper address bits", int'(ref_addr[AW-1:8]), 0);
      check(q.size() <= 1, "R5 granted cycles all started", q.size(), 0);
   endtask

   initial begin
      fork
         run_test();
         begin
            repeat (WD_CYCLES) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      if (wd_hit) check(1'b0, "R3 watchdog expired", cyc, WD_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule